// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port static memory with two fully independent ports, A and B. Each port has its own clock and its own synchronous active-low reset. Either port can read or write any word at any time, and both ports may access the same word in the same cycle. Each port captures its address, write data and controls in input registers on the rising edge of its clock. Each port steers its address through a loadable counter, so a burst of consecutive words needs only one address strobe followed by counter steps.

Each port has two chip enables of opposite polarity and two byte-lane enables. It also has a mode pin that selects between a flow-through read, where data follows the registered address in the same cycle, and a pipelined read, which adds one output register.

The read bus is modelled as a gated data word plus a valid flag in place of a tri-state driver. The depth is set by `ADDR_W`. The default is 10 (1K words) to keep elaboration small; `ADDR_W = 14` gives the full 16K-word array.

Top module: `dual_port_burst_ram`

## Requirements
- R1: Both ports read and write any word independently; simultaneous reads of one word by both ports both return its stored value.
- R2: A port is selected only in cycles whose registered `ce0_n` is 0 and `ce1` is 1; an unselected cycle writes nothing and drives `rdata` = 0 with `rvalid` = 0.
- R3: With `rw` = 0 at a selected edge, the word at the registered address is updated at the next edge of that port. Only the lanes whose `byte_n` bit is 0 change: bit 1 covers data bits 15:8 and bit 0 covers bits 7:0.
- R4: On a read, lanes whose registered `byte_n` bit is 1 are returned as zero.
- R5: With `pipe` = 0, read data and `rvalid` appear in the cycle that follows the edge that registered the read.
- R6: With `pipe` = 1, read data appears one cycle later than in flow-through mode, and `rvalid` is 0 in the cycle right after the edge that registered the read.
- R7: The address counter takes the following action at each edge, highest priority first: clear to 0 when `cnt_zero` = 1; load `addr` when `load_n` = 0; add one when `cnt_step` = 1; otherwise hold.
- R8: A step from the top address wraps the counter to address 0.
- R9: When both ports write one word in the same cycle on a shared clock, port A's data is stored in each lane that both ports enabled. Port B's data is stored in lanes that only port B enabled.
- R10: A read of a word that the other port writes in that same cycle returns the word's previous value.
- R11: When `oe_n` = 1, or the current registered cycle is a write, `rdata` is 0 and `rvalid` is 0.
- R12: Reset sets both counters to address 0 and clears the pipelined output register, so `rvalid` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A synchronous reset, active low |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_rw | input | 1 | Port A direction: 1 read, 0 write |
| a_byte_n | input | DW/8 | Port A lane enables, active low, bit 1 = bits 15:8 |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_pipe | input | 1 | Port A read mode: 0 flow-through, 1 pipelined |
| a_load_n | input | 1 | Port A address strobe, active low |
| a_cnt_step | input | 1 | Port A counter increment |
| a_cnt_zero | input | 1 | Port A counter clear |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, zero when not driven |
| a_rvalid | output | 1 | Port A read data valid |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B synchronous reset, active low |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_rw | input | 1 | Port B direction: 1 read, 0 write |
| b_byte_n | input | DW/8 | Port B lane enables, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_pipe | input | 1 | Port B read mode |
| b_load_n | input | 1 | Port B address strobe, active low |
| b_cnt_step | input | 1 | Port B counter increment |
| b_cnt_zero | input | 1 | Port B counter clear |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
The assertions check the following on every cycle:
- the counter's priority order, its wrap and its post-reset value;
- chip-select decoding into the registered select;
- the blanking of the read bus under output disable or a write;
- the one-cycle extra latency of the pipelined path.

Storage effects can only be shown through the bench's scenarios. These include:
- byte-lane merging and lane masking on reads;
- a write suppressed by a deselected chip enable;
- port A winning a same-word collision;
- read-old-data behaviour while the other port writes;
- bursts whose addresses are observed through the data they return.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-port burst RAM.
// Assumes data words are a whole number of 8-bit lanes.
package dpr_pkg;
    localparam int LANE_W = 8;

    // Read output timing choice per port.
    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;
endpackage

// File: rtl/dpr_port_front.sv
`timescale 1ns/1ps
// Input register stage and burst address counter for one port.
// Captures select, direction, lane enables and write data at each edge.
// The counter doubles as the registered address of the current access.
// Assumes a synchronous active-low reset in the port's clock domain.
module dpr_port_front #(
    parameter int AW = 10,
    parameter int DW = 16,
    parameter int NL = DW / dpr_pkg::LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce0_n,
    input  logic          ce1,
    input  logic          rw,
    input  logic [NL-1:0] byte_n,
    input  logic          load_n,
    input  logic          cnt_step,
    input  logic          cnt_zero,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] cnt_q,
    output logic          sel_q,
    output logic          wr_q,
    output logic [NL-1:0] lanes_q,
    output logic [DW-1:0] wdata_q
);
    localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

    logic sel_now;
    assign sel_now = !ce0_n && ce1;

    // Burst counter: clear, then load, then step, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_zero) begin
            cnt_q <= '0;
        end else if (!load_n) begin
            cnt_q <= addr;
        end else if (cnt_step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Control and data input registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
            lanes_q <= '0;
            wdata_q <= '0;
        end else begin
            sel_q   <= sel_now;
            wr_q    <= sel_now && !rw;
            lanes_q <= ~byte_n;
            wdata_q <= wdata;
        end
    end

    a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_zero |=> (cnt_q == '0));
    a_r7_load_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_zero && !load_n) |=> (cnt_q == $past(addr)));
    a_r7_step_third: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_zero && load_n && cnt_step && cnt_q != TOP_ADDR) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r7_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_zero && load_n && !cnt_step) |=> $stable(cnt_q));
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_zero && load_n && cnt_step && cnt_q == TOP_ADDR) |=> (cnt_q == '0));
    a_r2_select_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_n || !ce1) |=> (!sel_q && !wr_q));
    a_r12_counter_reset: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !sel_q));
endmodule

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
// One storage bank, written by a single port with per-lane enables and
// read asynchronously at two addresses. Two banks combined by XOR give
// two independent write ports without a shared writer.
// Assumes the writer presents data already folded with the other bank.
module dpr_bank #(
    parameter int AW = 10,
    parameter int DW = 16,
    parameter int NL = DW / dpr_pkg::LANE_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [NL-1:0] wlanes,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr0,
    input  logic [AW-1:0] raddr1,
    output logic [DW-1:0] rdata0,
    output logic [DW-1:0] rdata1
);
    localparam int DEPTH = 1 << AW;
    localparam int LW    = dpr_pkg::LANE_W;

    logic [DW-1:0] mem [DEPTH];

    // Lane-masked write of the folded data word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < NL; i++) begin
                if (wlanes[i]) begin
                    mem[waddr][i*LW +: LW] <= wdata[i*LW +: LW];
                end
            end
        end
    end

    // Asynchronous read at both addresses.
    always_comb begin
        rdata0 = mem[raddr0];
        rdata1 = mem[raddr1];
    end
endmodule

// File: rtl/dpr_out_stage.sv
`timescale 1ns/1ps
// Read output stage for one port: lane masking, optional pipeline
// register, and gating by output enable and write cycles.
// Assumes the mode input is held steady while reads are in flight.
module dpr_out_stage #(
    parameter int DW = 16,
    parameter int NL = DW / dpr_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dpr_pkg::out_mode_e mode,
    input  logic              oe_n,
    input  logic              sel_q,
    input  logic              wr_q,
    input  logic [NL-1:0]     lanes_q,
    input  logic [DW-1:0]     word,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    localparam int LW = dpr_pkg::LANE_W;

    logic [DW-1:0] flow_data;
    logic          flow_vld;
    logic [DW-1:0] pipe_data;
    logic          pipe_vld;
    logic [DW-1:0] pick_data;
    logic          pick_vld;

    // Zero the lanes the read did not enable.
    always_comb begin
        flow_data = '0;
        for (int i = 0; i < NL; i++) begin
            if (lanes_q[i]) begin
                flow_data[i*LW +: LW] = word[i*LW +: LW];
            end
        end
        flow_vld = sel_q && !wr_q;
    end

    // Extra output register for the pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_data <= '0;
            pipe_vld  <= 1'b0;
        end else begin
            pipe_data <= flow_data;
            pipe_vld  <= flow_vld;
        end
    end

    // Mode select and bus gating.
    always_comb begin
        pick_data = (mode == dpr_pkg::OUT_PIPE) ? pipe_data : flow_data;
        pick_vld  = (mode == dpr_pkg::OUT_PIPE) ? pipe_vld  : flow_vld;
        rvalid    = pick_vld && !oe_n && !wr_q;
        rdata     = rvalid ? pick_data : '0;
    end

    a_r11_bus_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || wr_q) |-> (rdata == '0 && !rvalid));
    a_r6_pipe_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == dpr_pkg::OUT_PIPE && !oe_n && !wr_q && $past(sel_q && !wr_q)) |-> rvalid);
    a_r5_flow_now: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == dpr_pkg::OUT_FLOW && !oe_n && sel_q && !wr_q) |-> rvalid);
    a_r12_pipe_cleared: assert property (@(posedge clk)
        !rst_n |=> !pipe_vld);
endmodule

// File: rtl/dual_port_burst_ram.sv
`timescale 1ns/1ps
// True dual-port synchronous RAM with per-port burst counters,
// byte-lane writes and selectable read latency.
// Storage is two XOR-folded banks, one owned by each port. Port B's
// lanes are suppressed where port A writes the same word in that cycle.
// Assumes same-word collisions are only meaningful on a shared clock.
module dual_port_burst_ram #(
    parameter int ADDR_W = 10,
    parameter int DW     = 16
) (
    input  logic            a_clk,
    input  logic            a_rst_n,
    input  logic            a_ce0_n,
    input  logic            a_ce1,
    input  logic            a_rw,
    input  logic [DW/8-1:0] a_byte_n,
    input  logic            a_oe_n,
    input  logic            a_pipe,
    input  logic            a_load_n,
    input  logic            a_cnt_step,
    input  logic            a_cnt_zero,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DW-1:0]   a_wdata,
    output logic [DW-1:0]   a_rdata,
    output logic            a_rvalid,
    input  logic            b_clk,
    input  logic            b_rst_n,
    input  logic            b_ce0_n,
    input  logic            b_ce1,
    input  logic            b_rw,
    input  logic [DW/8-1:0] b_byte_n,
    input  logic            b_oe_n,
    input  logic            b_pipe,
    input  logic            b_load_n,
    input  logic            b_cnt_step,
    input  logic            b_cnt_zero,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DW-1:0]   b_wdata,
    output logic [DW-1:0]   b_rdata,
    output logic            b_rvalid
);
    localparam int NL = DW / dpr_pkg::LANE_W;

    logic [ADDR_W-1:0] cnt_a, cnt_b;
    logic              sel_a, sel_b, wr_a, wr_b;
    logic [NL-1:0]     ln_a, ln_b, clash, ln_b_eff;
    logic [DW-1:0]     wd_a, wd_b;
    logic [DW-1:0]     ra_at_a, ra_at_b, rb_at_a, rb_at_b;
    logic [DW-1:0]     word_a, word_b;

    dpr_port_front #(.AW(ADDR_W), .DW(DW), .NL(NL)) front_a (
        .clk(a_clk), .rst_n(a_rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .rw(a_rw),
        .byte_n(a_byte_n), .load_n(a_load_n), .cnt_step(a_cnt_step),
        .cnt_zero(a_cnt_zero), .addr(a_addr), .wdata(a_wdata),
        .cnt_q(cnt_a), .sel_q(sel_a), .wr_q(wr_a), .lanes_q(ln_a), .wdata_q(wd_a)
    );

    dpr_port_front #(.AW(ADDR_W), .DW(DW), .NL(NL)) front_b (
        .clk(b_clk), .rst_n(b_rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .rw(b_rw),
        .byte_n(b_byte_n), .load_n(b_load_n), .cnt_step(b_cnt_step),
        .cnt_zero(b_cnt_zero), .addr(b_addr), .wdata(b_wdata),
        .cnt_q(cnt_b), .sel_q(sel_b), .wr_q(wr_b), .lanes_q(ln_b), .wdata_q(wd_b)
    );

    // Port A owns lanes it writes; B loses those lanes on a same-word clash.
    always_comb begin
        clash    = (wr_a && cnt_a == cnt_b) ? ln_a : '0;
        ln_b_eff = ln_b & ~clash;
    end

    dpr_bank #(.AW(ADDR_W), .DW(DW), .NL(NL)) bank_a (
        .clk(a_clk), .we(wr_a), .waddr(cnt_a), .wlanes(ln_a),
        .wdata(wd_a ^ rb_at_a),
        .raddr0(cnt_a), .raddr1(cnt_b), .rdata0(ra_at_a), .rdata1(ra_at_b)
    );

    dpr_bank #(.AW(ADDR_W), .DW(DW), .NL(NL)) bank_b (
        .clk(b_clk), .we(wr_b), .waddr(cnt_b), .wlanes(ln_b_eff),
        .wdata(wd_b ^ ra_at_b),
        .raddr0(cnt_b), .raddr1(cnt_a), .rdata0(rb_at_b), .rdata1(rb_at_a)
    );

    // Stored word as seen by each port.
    always_comb begin
        word_a = ra_at_a ^ rb_at_a;
        word_b = ra_at_b ^ rb_at_b;
    end

    dpr_out_stage #(.DW(DW), .NL(NL)) out_a (
        .clk(a_clk), .rst_n(a_rst_n), .mode(dpr_pkg::out_mode_e'(a_pipe)),
        .oe_n(a_oe_n), .sel_q(sel_a), .wr_q(wr_a), .lanes_q(ln_a), .word(word_a),
        .rdata(a_rdata), .rvalid(a_rvalid)
    );

    dpr_out_stage #(.DW(DW), .NL(NL)) out_b (
        .clk(b_clk), .rst_n(b_rst_n), .mode(dpr_pkg::out_mode_e'(b_pipe)),
        .oe_n(b_oe_n), .sel_q(sel_b), .wr_q(wr_b), .lanes_q(ln_b), .word(word_b),
        .rdata(b_rdata), .rvalid(b_rvalid)
    );

    a_r9_b_yields_lanes: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (wr_a && wr_b && cnt_a == cnt_b) |-> ((ln_b_eff & ln_a) == '0));
endmodule

// File: tb/dual_port_burst_ram_tb_top.sv
`timescale 1ns/1ps
// Directed bench: both ports share one 50 MHz clock so that
// same-cycle collisions are well defined.
module dual_port_burst_ram_tb_top;
    localparam int AW = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       ce0_n [2];
    logic       ce1 [2];
    logic       rw [2];
    logic [1:0] byte_n [2];
    logic       oe_n [2];
    logic       pipe [2];
    logic       load_n [2];
    logic       step [2];
    logic       zero [2];
    logic [AW-1:0] addr [2];
    logic [DW-1:0] wdata [2];
    logic [DW-1:0] rdata [2];
    logic          rvalid [2];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dual_port_burst_ram #(.ADDR_W(AW), .DW(DW)) dut_i (
        .a_clk(clk), .a_rst_n(rst_n), .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]), .a_rw(rw[0]),
        .a_byte_n(byte_n[0]), .a_oe_n(oe_n[0]), .a_pipe(pipe[0]), .a_load_n(load_n[0]),
        .a_cnt_step(step[0]), .a_cnt_zero(zero[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
        .a_rdata(rdata[0]), .a_rvalid(rvalid[0]),
        .b_clk(clk), .b_rst_n(rst_n), .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]), .b_rw(rw[1]),
        .b_byte_n(byte_n[1]), .b_oe_n(oe_n[1]), .b_pipe(pipe[1]), .b_load_n(load_n[1]),
        .b_cnt_step(step[1]), .b_cnt_zero(zero[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
        .b_rdata(rdata[1]), .b_rvalid(rvalid[1])
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic req(input int p, input logic sel, input logic r, input logic [1:0] be,
                       input logic ld_n, input logic st, input logic zr,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce0_n[p] = !sel; ce1[p] = sel; rw[p] = r; byte_n[p] = be;
        load_n[p] = ld_n; step[p] = st; zero[p] = zr; addr[p] = a; wdata[p] = d;
    endtask

    task automatic idle(input int p);
        req(p, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [1:0] be);
        req(p, 1'b1, 1'b0, be, 1'b0, 1'b0, 1'b0, a, d);
        tick();
        idle(p);
    endtask

    task automatic rd(input int p, input logic [AW-1:0] a, input logic [1:0] be,
                      output logic [DW-1:0] d, output logic v);
        req(p, 1'b1, 1'b1, be, 1'b0, 1'b0, 1'b0, a, '0);
        tick();
        d = rdata[p];
        v = rvalid[p];
        idle(p);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // R12: reset state, counters at zero, pipeline cleared.
    task automatic t_reset();
        logic [DW-1:0] d; logic v;
        check("R12 rvalid A after reset", {31'd0, rvalid[0]}, 32'd0);
        check("R12 rdata B after reset", {16'd0, rdata[1]}, 32'd0);
        wr(0, 10'd0, 16'h1234, 2'b00);
        wr(0, 10'd5, 16'h0BAD, 2'b00);
        pipe[1] = 1'b1;
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd5, '0);
        tick();
        idle(1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R12 pipe register cleared", {31'd0, rvalid[1]}, 32'd0);
        pipe[1] = 1'b0;
        req(0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 10'd5, '0);
        tick();
        check("R12 counter A at zero", {16'd0, rdata[0]}, 32'h1234);
        idle(0);
        rd(1, 10'd5, 2'b00, d, v);
        check("R12 memory kept", {16'd0, d}, 32'h0BAD);
    endtask

    // R1, R5: independent access and same-word reads on both ports.
    task automatic t_basic();
        logic [DW-1:0] d; logic v;
        req(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd20, 16'hA020);
        req(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd21, 16'hB021);
        tick();
        idle(0); idle(1);
        rd(1, 10'd20, 2'b00, d, v);
        check("R1 B reads A's word", {16'd0, d}, 32'hA020);
        check("R5 flow valid", {31'd0, v}, 32'd1);
        rd(0, 10'd21, 2'b00, d, v);
        check("R1 A reads B's word", {16'd0, d}, 32'hB021);
        req(0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd20, '0);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd20, '0);
        tick();
        check("R1 same word A", {16'd0, rdata[0]}, 32'hA020);
        check("R1 same word B", {16'd0, rdata[1]}, 32'hA020);
        idle(0); idle(1);
    endtask

    // R3, R4: byte-lane writes and lane masking on reads.
    task automatic t_lanes();
        logic [DW-1:0] d; logic v;
        wr(0, 10'd60, 16'h1234, 2'b00);
        wr(0, 10'd60, 16'hABCD, 2'b01);
        rd(1, 10'd60, 2'b00, d, v);
        check("R3 upper lane only", {16'd0, d}, 32'hAB34);
        wr(1, 10'd60, 16'h99EF, 2'b10);
        rd(0, 10'd60, 2'b00, d, v);
        check("R3 lower lane only", {16'd0, d}, 32'hABEF);
        rd(0, 10'd60, 2'b10, d, v);
        check("R4 upper masked on read", {16'd0, d}, 32'h00EF);
        rd(1, 10'd60, 2'b01, d, v);
        check("R4 lower masked on read", {16'd0, d}, 32'hAB00);
    endtask

    // R2: deselected cycles neither write nor drive.
    task automatic t_select();
        logic [DW-1:0] d; logic v;
        wr(0, 10'd50, 16'h5555, 2'b00);
        req(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd50, 16'hDEAD);
        ce1[0] = 1'b0;
        tick();
        idle(0);
        rd(1, 10'd50, 2'b00, d, v);
        check("R2 ce1 low blocks write", {16'd0, d}, 32'h5555);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd50, '0);
        ce0_n[1] = 1'b1;
        tick();
        check("R2 deselected rvalid", {31'd0, rvalid[1]}, 32'd0);
        check("R2 deselected rdata", {16'd0, rdata[1]}, 32'd0);
        idle(1);
    endtask

    // R6: pipelined read arrives one cycle later.
    task automatic t_pipe();
        pipe[1] = 1'b1;
        wr(0, 10'd70, 16'h7070, 2'b00);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd70, '0);
        tick();
        check("R6 not yet valid", {31'd0, rvalid[1]}, 32'd0);
        idle(1);
        tick();
        check("R6 data one cycle later", {16'd0, rdata[1]}, 32'h7070);
        check("R6 valid one cycle later", {31'd0, rvalid[1]}, 32'd1);
        pipe[1] = 1'b0;
        tick();
    endtask

    // R7: burst writes and reads, and counter priority.
    task automatic t_burst();
        logic [DW-1:0] d; logic v;
        req(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd100, 16'hC100);
        tick();
        for (int i = 1; i < 4; i++) begin
            req(0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, '0, 16'hC100 + 16'(i));
            tick();
        end
        idle(0);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd100, '0);
        tick();
        check("R7 burst word 0", {16'd0, rdata[1]}, 32'hC100);
        for (int i = 1; i < 4; i++) begin
            req(1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, '0, '0);
            tick();
            check("R7 burst step", {16'd0, rdata[1]}, 32'hC100 + i);
        end
        req(1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 10'd0, '0);
        tick();
        check("R7 hold keeps address", {16'd0, rdata[1]}, 32'hC103);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 10'd101, '0);
        tick();
        check("R7 load beats step", {16'd0, rdata[1]}, 32'hC101);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 10'd102, '0);
        tick();
        check("R7 clear beats load", {16'd0, rdata[1]}, 32'h1234);
        idle(1);
        rd(0, 10'd102, 2'b00, d, v);
        check("R7 burst word 2 via A", {16'd0, d}, 32'hC102);
    endtask

    // R8: counter wraps from the top address to zero.
    task automatic t_wrap();
        wr(0, 10'd1023, 16'hE0E0, 2'b00);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd1023, '0);
        tick();
        check("R8 top word", {16'd0, rdata[1]}, 32'hE0E0);
        req(1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, '0, '0);
        tick();
        check("R8 wrapped to zero", {16'd0, rdata[1]}, 32'h1234);
        idle(1);
    endtask

    // R9: same-word writes on both ports, A wins shared lanes.
    task automatic t_clash();
        logic [DW-1:0] d; logic v;
        req(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd200, 16'hAAAA);
        req(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd200, 16'hBBBB);
        tick();
        idle(0); idle(1);
        rd(1, 10'd200, 2'b00, d, v);
        check("R9 A wins both lanes", {16'd0, d}, 32'hAAAA);
        req(0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 10'd201, 16'h0011);
        req(1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd201, 16'h2222);
        tick();
        idle(0); idle(1);
        rd(0, 10'd201, 2'b00, d, v);
        check("R9 lanes split A low B high", {16'd0, d}, 32'h2211);
    endtask

    // R10, R11: read during write, write cycle and output disable blanking.
    task automatic t_overlap();
        logic [DW-1:0] d; logic v;
        wr(0, 10'd300, 16'h1111, 2'b00);
        req(0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 10'd300, 16'h2222);
        req(1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 10'd300, '0);
        tick();
        check("R10 old data while written", {16'd0, rdata[1]}, 32'h1111);
        check("R11 write cycle rvalid low", {31'd0, rvalid[0]}, 32'd0);
        check("R11 write cycle rdata zero", {16'd0, rdata[0]}, 32'd0);
        idle(0); idle(1);
        rd(1, 10'd300, 2'b00, d, v);
        check("R10 new data afterwards", {16'd0, d}, 32'h2222);
        oe_n[1] = 1'b1;
        rd(1, 10'd300, 2'b00, d, v);
        check("R11 oe_n high rdata zero", {16'd0, d}, 32'd0);
        check("R11 oe_n high rvalid low", {31'd0, v}, 32'd0);
        oe_n[1] = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            idle(p);
            oe_n[p] = 1'b0;
            pipe[p] = 1'b0;
        end
        @(negedge clk);
        do_reset();
        t_reset();
        t_basic();
        t_lanes();
        t_select();
        t_pipe();
        t_burst();
        t_wrap();
        t_clash();
        t_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule